// File: doc/BRIEF.md
# Acquisition Program Sequencer

This block keeps a short program of acquisition instructions and plays it out to a converter. Each instruction is 48 bits wide, split into three 16-bit words: a command word (channel, resolution and sampling-time fields, carried to the converter as one word) and two threshold words. A host reaches the program through a narrow data window. A 2-bit word selector in the control register picks which of the three words an address touches. The same address map serves a 16-bit host and an 8-bit host; in byte mode the lowest address bit picks the byte lane.

Once the host sets the run bit, the block issues one conversion request per instruction, in ascending order. Each request is a single-cycle strobe that carries the instruction's command word and its index. The block then waits for the converter's done strobe before it moves on. After the last instruction it wraps to the first for as long as the run bit stays set. Clearing the run bit, or writing the soft-reset bit, lets the instruction in flight finish before the block goes idle. A soft reset also sends the program counter back to instruction 0. A busy flag in the control register shows whether a request is still outstanding.

Top module: `acq_prog_seq`

## Requirements
- R1: The store holds 8 instructions of three 16-bit words each. Every word can be written and read back in any order through `ram_addr`/`ram_wdata`/`ram_rdata`. All words read zero after hardware reset.
- R2: Control-register bits 9:8 form the word selector: 0 selects the command word, 1 the first threshold word, 2 the second threshold word. Bits 9:8 of `cfg_rdata` return the stored selector.
- R3: Selector value 3 is reserved. A RAM write under it changes nothing, and `ram_rdata` reads 0 under it.
- R4: With `bus_byte`=0, the instruction index is `ram_addr[3:1]` and `ram_addr[0]` is ignored. With `ram_addr[4]`=1 the address is out of range: a write changes nothing and a read returns 0.
- R5: With `bus_byte`=1, the instruction index is `ram_addr[3:1]`, and `ram_addr[0]` picks the low byte (0) or the high byte (1). A write stores `ram_wdata[7:0]` into that byte only. A read returns that byte in `ram_rdata[7:0]`, with the upper bits zero.
- R6: Writing the control register with bit 1 set sets the run bit, and bit 1 of `cfg_rdata` reads it back. Bit 0 of `cfg_rdata` is 1 while a request is outstanding and 0 when the block is idle.
- R7: `conv_req` is high for exactly one cycle per instruction. During that cycle `conv_cmd` carries the command word and `conv_idx` the instruction index. No further request is issued until `conv_done` has been seen.
- R8: Instructions run in ascending index order. After index 7 the block wraps to index 0 while the run bit stays set.
- R9: Clearing the run bit stops the block only after the outstanding instruction receives `conv_done`. A later start resumes at the next index.
- R10: Writing control bit 2 clears the run bit. If a request is outstanding, the block waits for its `conv_done` and then goes idle at index 0. If the block is already idle, the index returns to 0 at once.
- R11: After `rst_n` the block is idle, the run bit and the selector are 0, the index is 0 and `conv_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_byte | input | 1 | 1 selects the 8-bit host map, 0 the 16-bit map |
| ram_we | input | 1 | Program-store write strobe |
| ram_addr | input | 5 | Program-store address |
| ram_wdata | input | 16 | Program-store write data |
| ram_rdata | output | 16 | Program-store read data (combinational) |
| cfg_we | input | 1 | Control-register write strobe |
| cfg_wdata | input | 16 | Control write data: bit 1 run, bit 2 soft reset, bits 9:8 selector |
| cfg_rdata | output | 16 | Control read data: bit 0 busy, bit 1 run, bits 9:8 selector |
| conv_req | output | 1 | One-cycle conversion request strobe |
| conv_idx | output | 3 | Index of the requested instruction |
| conv_cmd | output | 16 | Command word of the requested instruction |
| conv_done | input | 1 | Converter completion strobe |

## Verification
The hardest situation to reach from the ports is a stop or soft reset that lands while a request is outstanding. The block must keep the busy flag set, withhold the next request and settle at the right index only when the done strobe finally arrives. The stimulus watches for each request strobe and, on that same cycle, writes the control register. It holds back `conv_done` for a random number of cycles, checks that no further request appears in that gap, and then restarts to see which index the block resumes from. The reserved selector, out-of-range addresses and single-byte writes are reached by random host traffic that mixes both bus widths and all four selector values against a word-level model.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
   localparam int SECT_W   = 16;
   localparam int N_SECT   = 3;
   localparam int PTR_W    = 2;
   localparam int BYTE_W   = 8;
   localparam int N_LANE   = SECT_W / BYTE_W;
   localparam int CFG_BUSY = 0;
   localparam int CFG_RUN  = 1;
   localparam int CFG_SRST = 2;
   localparam int CFG_PTR  = 8;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_WAIT  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/acq_host_decode.sv
module acq_host_decode
   import acq_seq_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic                     bus_byte,
   input  logic [IDX_W+1:0]         addr,
   input  logic [PTR_W-1:0]         ptr,
   output logic                     hit,
   output logic [IDX_W-1:0]         idx,
   output logic [PTR_W-1:0]         sect,
   output logic [N_LANE-1:0]        lane_en
);
   localparam logic [PTR_W-1:0] PTR_RSVD = PTR_W'(N_SECT);

   always_comb begin
      idx  = addr[IDX_W:1];
      sect = ptr;
      hit  = (addr[IDX_W+1] == 1'b0) && (ptr != PTR_RSVD);
      if (bus_byte) lane_en = addr[0] ? 2'b10 : 2'b01;
      else          lane_en = 2'b11;
   end
endmodule

// File: rtl/acq_instr_store.sv
module acq_instr_store
   import acq_seq_pkg::*;
#(
   parameter int N_INSTR = 8,
   parameter int IDX_W   = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic                 hit,
   input  logic                 bus_byte,
   input  logic [IDX_W-1:0]     idx,
   input  logic [PTR_W-1:0]     sect,
   input  logic [N_LANE-1:0]    lane_en,
   input  logic [SECT_W-1:0]    wdata,
   output logic [SECT_W-1:0]    rdata,
   input  logic [IDX_W-1:0]     seq_idx,
   output logic [SECT_W-1:0]    seq_word
);
   localparam int TOTAL_W = N_INSTR * N_SECT * SECT_W;

   logic [TOTAL_W-1:0] mem_flat;
   logic [SECT_W-1:0]  host_word;
   logic [PTR_W-1:0]   sect_c;

   for (genvar gi = 0; gi < N_INSTR; gi++) begin : g_ins
      for (genvar gs = 0; gs < N_SECT; gs++) begin : g_sec
         logic sel;
         assign sel = we && hit && (idx == IDX_W'(gi)) && (sect == PTR_W'(gs));
         for (genvar gl = 0; gl < N_LANE; gl++) begin : g_lane
            logic [BYTE_W-1:0] byte_q;
            logic [BYTE_W-1:0] byte_d;
            assign byte_d = bus_byte ? wdata[BYTE_W-1:0] : wdata[gl*BYTE_W +: BYTE_W];
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                 byte_q <= '0;
               else if (sel && lane_en[gl]) byte_q <= byte_d;
            end
            assign mem_flat[((gi*N_SECT+gs)*SECT_W) + gl*BYTE_W +: BYTE_W] = byte_q;
         end
      end
   end

   always_comb begin
      sect_c    = (sect >= PTR_W'(N_SECT)) ? '0 : sect;
      host_word = mem_flat[(int'(idx)*N_SECT + int'(sect_c))*SECT_W +: SECT_W];
      if (!hit)          rdata = '0;
      else if (bus_byte) rdata = {{(SECT_W-BYTE_W){1'b0}},
                                  lane_en[1] ? host_word[SECT_W-1:BYTE_W] : host_word[BYTE_W-1:0]};
      else               rdata = host_word;
      seq_word  = mem_flat[(int'(seq_idx)*N_SECT)*SECT_W +: SECT_W];
   end

   // R3 / R4: a write that misses the map must leave every stored word alone
   p_ignored_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !hit) |=> $stable(mem_flat));
endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
   import acq_seq_pkg::*;
#(
   parameter int N_INSTR = 8,
   parameter int IDX_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_run,
   input  logic             cfg_srst,
   input  logic             conv_done,
   output logic             run_q,
   output logic             busy,
   output logic             conv_req,
   output logic [IDX_W-1:0] pc
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_INSTR - 1);

   seq_state_e state_q;
   logic       rst_pend_q;
   logic       rst_now;
   logic       stop_now;
   logic       home;

   assign rst_now  = cfg_we && cfg_srst;
   assign stop_now = cfg_we && (cfg_srst || !cfg_run);
   assign home     = rst_pend_q || rst_now;
   assign busy     = (state_q != SQ_IDLE);
   assign conv_req = (state_q == SQ_ISSUE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SQ_IDLE;
         pc         <= '0;
         run_q      <= 1'b0;
         rst_pend_q <= 1'b0;
      end else begin
         if (cfg_we) run_q <= cfg_run && !cfg_srst;
         if (rst_now && busy) rst_pend_q <= 1'b1;
         unique case (state_q)
            SQ_IDLE: begin
               if (rst_now)                   pc <= '0;
               else if (run_q && !stop_now)   state_q <= SQ_ISSUE;
            end
            SQ_ISSUE: state_q <= SQ_WAIT;
            SQ_WAIT: begin
               if (conv_done) begin
                  if (home) begin
                     pc         <= '0;
                     rst_pend_q <= 1'b0;
                     state_q    <= SQ_IDLE;
                  end else begin
                     pc      <= (pc == LAST) ? '0 : pc + 1'b1;
                     state_q <= (run_q && !stop_now) ? SQ_ISSUE : SQ_IDLE;
                  end
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   // R7: the request strobe lasts a single cycle
   p_req_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> !conv_req);
   // R7: while waiting without done, the index holds and the block stays busy
   p_hold_until_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_WAIT && !conv_done) |=> ($stable(pc) && busy && !conv_req));
   // R8: completion of the last instruction wraps to index 0
   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_WAIT && conv_done && !home && pc == LAST) |=> (pc == '0));
   // R9: a stop request during a pending conversion keeps the block busy
   p_stop_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_WAIT && !conv_done && cfg_we && !cfg_run) |=> busy);
   // R10: a pending soft reset ends idle at index 0
   p_reset_home_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_WAIT && conv_done && home) |=> (!busy && pc == '0 && !run_q));
endmodule

// File: rtl/acq_prog_seq.sv
module acq_prog_seq
   import acq_seq_pkg::*;
#(
   parameter int N_INSTR = 8,
   parameter int IDX_W   = $clog2(N_INSTR),
   parameter int ADDR_W  = IDX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_byte,
   input  logic              ram_we,
   input  logic [ADDR_W-1:0] ram_addr,
   input  logic [SECT_W-1:0] ram_wdata,
   output logic [SECT_W-1:0] ram_rdata,
   input  logic              cfg_we,
   input  logic [SECT_W-1:0] cfg_wdata,
   output logic [SECT_W-1:0] cfg_rdata,
   output logic              conv_req,
   output logic [IDX_W-1:0]  conv_idx,
   output logic [SECT_W-1:0] conv_cmd,
   input  logic              conv_done
);
   if (N_INSTR < 2 || (1 << IDX_W) != N_INSTR) begin : g_bad_depth
      $error("N_INSTR must be a power of two of at least 2");
   end
   if (ADDR_W != IDX_W + 2) begin : g_bad_addr
      $error("ADDR_W must equal IDX_W + 2");
   end

   logic [PTR_W-1:0]  ptr_q;
   logic              hit;
   logic [IDX_W-1:0]  dec_idx;
   logic [PTR_W-1:0]  dec_sect;
   logic [N_LANE-1:0] lane_en;
   logic              run_q;
   logic              busy;
   logic [IDX_W-1:0]  pc;
   logic              unused_cfg_bits;

   assign unused_cfg_bits = ^{cfg_wdata[SECT_W-1:CFG_PTR+PTR_W], cfg_wdata[CFG_PTR-1:CFG_SRST+1],
                              cfg_wdata[CFG_BUSY]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_q <= '0;
      else if (cfg_we) ptr_q <= cfg_wdata[CFG_PTR +: PTR_W];
   end

   always_comb begin
      cfg_rdata                     = '0;
      cfg_rdata[CFG_BUSY]           = busy;
      cfg_rdata[CFG_RUN]            = run_q;
      cfg_rdata[CFG_PTR +: PTR_W]   = ptr_q;
   end

   acq_host_decode #(.IDX_W(IDX_W)) i_dec (
      .bus_byte (bus_byte),
      .addr     (ram_addr),
      .ptr      (ptr_q),
      .hit      (hit),
      .idx      (dec_idx),
      .sect     (dec_sect),
      .lane_en  (lane_en)
   );

   acq_instr_store #(.N_INSTR(N_INSTR), .IDX_W(IDX_W)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ram_we),
      .hit      (hit),
      .bus_byte (bus_byte),
      .idx      (dec_idx),
      .sect     (dec_sect),
      .lane_en  (lane_en),
      .wdata    (ram_wdata),
      .rdata    (ram_rdata),
      .seq_idx  (pc),
      .seq_word (conv_cmd)
   );

   acq_seq_ctrl #(.N_INSTR(N_INSTR), .IDX_W(IDX_W)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_run   (cfg_wdata[CFG_RUN]),
      .cfg_srst  (cfg_wdata[CFG_SRST]),
      .conv_done (conv_done),
      .run_q     (run_q),
      .busy      (busy),
      .conv_req  (conv_req),
      .pc        (pc)
   );

   assign conv_idx = pc;

   // R2: the selector written to the control register is read back
   p_selector_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg_rdata[CFG_PTR +: PTR_W] == $past(cfg_wdata[CFG_PTR +: PTR_W])));
   // R3: the reserved selector reads as zero
   p_reserved_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q == PTR_W'(N_SECT)) |-> (ram_rdata == '0));
   // R5: byte-wide reads keep the upper half clear
   p_byte_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_byte |-> (ram_rdata[SECT_W-1:BYTE_W] == '0));
endmodule

// File: tb/test_acq_prog_seq.sv
module test_acq_prog_seq;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_byte = 1'b0;
   logic        ram_we = 1'b0;
   logic [4:0]  ram_addr = '0;
   logic [15:0] ram_wdata = '0;
   logic [15:0] ram_rdata;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        conv_req;
   logic [2:0]  conv_idx;
   logic [15:0] conv_cmd;
   logic        conv_done = 1'b0;

   logic [15:0] model [8][3];
   logic [1:0]  cur_ptr;
   int          checks = 0;
   int          fails = 0;
   bit          done_flag = 0;
   int unsigned seed_dummy;

   always #(CLK_P/2) clk = ~clk;

   acq_prog_seq i_acq_prog_seq (
      .clk(clk), .rst_n(rst_n), .bus_byte(bus_byte), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .conv_req(conv_req), .conv_idx(conv_idx), .conv_cmd(conv_cmd),
      .conv_done(conv_done)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_read(input bit bb, input logic [4:0] a, input logic [1:0] p);
      logic [15:0] w;
      if (a[4] || p == 2'd3) return 16'h0;
      w = model[a[3:1]][p];
      if (bb) return a[0] ? {8'h0, w[15:8]} : {8'h0, w[7:0]};
      return w;
   endfunction

   function automatic string tag_of(input bit bb, input logic [4:0] a, input logic [1:0] p);
      if (p == 2'd3) return "R3";
      if (a[4])      return "R4";
      if (bb)        return "R5";
      return "R1";
   endfunction

   // all tasks start and end just after a falling edge
   task automatic cfg_write(input logic [15:0] d);
      cfg_we = 1'b1; cfg_wdata = d;
      @(negedge clk); #1;
      cfg_we = 1'b0;
      if (!d[2]) cur_ptr = d[9:8]; else cur_ptr = d[9:8];
   endtask

   task automatic ram_write(input bit bb, input logic [4:0] a, input logic [15:0] d);
      bus_byte = bb; ram_addr = a; ram_wdata = d; ram_we = 1'b1;
      @(negedge clk); #1;
      ram_we = 1'b0;
      if (!a[4] && cur_ptr != 2'd3) begin
         if (!bb)       model[a[3:1]][cur_ptr] = d;
         else if (a[0]) model[a[3:1]][cur_ptr][15:8] = d[7:0];
         else           model[a[3:1]][cur_ptr][7:0] = d[7:0];
      end
   endtask

   task automatic ram_read_check(input bit bb, input logic [4:0] a);
      logic [15:0] e;
      bus_byte = bb; ram_addr = a; #1;
      e = exp_read(bb, a, cur_ptr);
      check(ram_rdata == e, tag_of(bb, a, cur_ptr), 32'(ram_rdata), 32'(e));
      @(negedge clk); #1;
   endtask

   task automatic wait_req(output bit found);
      found = 0;
      for (int k = 0; k < 30; k++) begin
         if (conv_req) begin found = 1; break; end
         @(negedge clk); #1;
      end
   endtask

   // expects a request for index ei, then completes it after a gap
   task automatic run_one(input int ei, input int gap, input string req);
      bit f;
      wait_req(f);
      check(f, req, 32'(f), 32'd1);
      check(conv_idx == 3'(ei), req, 32'(conv_idx), 32'(ei));
      check(conv_cmd == model[ei][0], "R7", 32'(conv_cmd), 32'(model[ei][0]));
      @(negedge clk); #1;
      check(conv_req == 1'b0 && cfg_rdata[0] == 1'b1, "R7", 32'({conv_req, cfg_rdata[0]}), 32'b01);
      for (int g = 0; g < gap; g++) begin
         @(negedge clk); #1;
         check(conv_req == 1'b0, "R7", 32'(conv_req), 32'd0);
      end
      conv_done = 1'b1;
      @(negedge clk); #1;
      conv_done = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1;
         fails++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      bit f;
      seed_dummy = $urandom(32'h5eed_0042);
      cur_ptr = 2'd0;
      for (int i = 0; i < 8; i++) for (int s = 0; s < 3; s++) model[i][s] = 16'h0;
      repeat (3) @(negedge clk);
      #1;
      // R11: reset state
      check(cfg_rdata == 16'h0, "R11", 32'(cfg_rdata), 32'h0);
      check(conv_req == 1'b0 && conv_idx == 3'd0, "R11", 32'({conv_req, conv_idx}), 32'h0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(ram_rdata == 16'h0, "R1", 32'(ram_rdata), 32'h0);

      // directed: reserved selector write ignored (R3)
      cfg_write(16'h0000);
      ram_write(1'b0, 5'd2, 16'h1234);
      cfg_write(16'h0300);
      check(cfg_rdata[9:8] == 2'd3, "R2", 32'(cfg_rdata[9:8]), 32'd3);
      ram_write(1'b0, 5'd2, 16'hDEAD);
      ram_read_check(1'b0, 5'd2);
      cfg_write(16'h0000);
      ram_read_check(1'b0, 5'd2);
      ram_read_check(1'b0, 5'd3);   // R4: addr[0] ignored in word mode
      ram_write(1'b0, 5'd18, 16'hBEEF); // R4: out of range
      ram_read_check(1'b0, 5'd2);
      ram_read_check(1'b0, 5'd18);
      ram_write(1'b1, 5'd3, 16'h00A5);  // R5: high byte only
      ram_read_check(1'b0, 5'd2);
      ram_read_check(1'b1, 5'd2);
      ram_read_check(1'b1, 5'd3);

      // random host traffic (R1..R5)
      for (int n = 0; n < 400; n++) begin
         int unsigned r = $urandom;
         bit bb = r[0];
         logic [4:0] a = 5'(r[8:4]);
         if (r[3:1] == 3'd0) begin
            cfg_write({6'h0, 2'(r[11:10]), 8'h0});
            check(cfg_rdata[9:8] == 2'(r[11:10]), "R2", 32'(cfg_rdata[9:8]), 32'(r[11:10]));
         end else if (r[3:1] < 3'd4) begin
            ram_write(bb, a, 16'($urandom));
         end else begin
            ram_read_check(bb, a);
         end
      end

      // program command words
      cfg_write(16'h0000);
      for (int i = 0; i < 8; i++) ram_write(1'b0, 5'(i*2), 16'($urandom));
      for (int i = 0; i < 8; i++) ram_read_check(1'b0, 5'(i*2));

      // R6 start, R7/R8 order and wrap
      cfg_write(16'h0002);
      check(cfg_rdata[1] == 1'b1, "R6", 32'(cfg_rdata[1]), 32'd1);
      for (int k = 0; k < 11; k++) run_one(k % 8, int'($urandom % 4), "R8");

      // R9: stop while outstanding (request for index 3)
      wait_req(f);
      check(f && conv_idx == 3'd3, "R9", 32'(conv_idx), 32'd3);
      cfg_write(16'h0000);
      check(cfg_rdata[1:0] == 2'b01, "R9", 32'(cfg_rdata[1:0]), 32'b01);
      repeat (2) begin @(negedge clk); #1; end
      check(cfg_rdata[0] == 1'b1 && !conv_req, "R9", 32'(cfg_rdata[0]), 32'd1);
      conv_done = 1'b1; @(negedge clk); #1; conv_done = 1'b0;
      for (int g = 0; g < 5; g++) begin @(negedge clk); #1; end
      check(cfg_rdata[0] == 1'b0 && !conv_req, "R9", 32'({cfg_rdata[0], conv_req}), 32'd0);
      cfg_write(16'h0002);
      // resumes at index 4; R10: soft reset while outstanding
      wait_req(f);
      check(f && conv_idx == 3'd4, "R9", 32'(conv_idx), 32'd4);
      cfg_write(16'h0004);
      check(cfg_rdata[1:0] == 2'b01, "R10", 32'(cfg_rdata[1:0]), 32'b01);
      conv_done = 1'b1; @(negedge clk); #1; conv_done = 1'b0;
      for (int g = 0; g < 4; g++) begin @(negedge clk); #1; end
      check(cfg_rdata[0] == 1'b0 && !conv_req, "R10", 32'(cfg_rdata[0]), 32'd0);
      cfg_write(16'h0002);
      run_one(0, 1, "R10");
      // stop after index 1, then soft reset while idle
      wait_req(f);
      check(f && conv_idx == 3'd1, "R8", 32'(conv_idx), 32'd1);
      cfg_write(16'h0000);
      conv_done = 1'b1; @(negedge clk); #1; conv_done = 1'b0;
      for (int g = 0; g < 3; g++) begin @(negedge clk); #1; end
      cfg_write(16'h0004);
      cfg_write(16'h0002);
      run_one(0, 0, "R10");
      run_one(1, 2, "R8");
      cfg_write(16'h0004);
      conv_done = 1'b1; @(negedge clk); #1; conv_done = 1'b0;

      if (!done_flag) begin
         done_flag = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule